// File: doc/BRIEF.md
# Prescaled Countdown Interval Timer

This block is a 12-bit down-counting timer that a processor core uses to pace slow background jobs that run outside the sample-by-sample processing loop, such as polling a supply level or a front-panel control. Software sets a reload value, a 3-bit prescale exponent and a mode bit, then pulses start. The counter steps down once per prescaled tick. On the tick that finds it already at zero, the counter expires and sets a sticky interrupt request toward the core.

Two modes exist. In one-shot mode the timer halts at expiry and keeps a count of zero until software starts it again. In continuous mode it reloads at each expiry and keeps running, so it requests an interrupt once per period. The period is (reload+1) × 2^p clock cycles, where p is the prescale exponent. The core clears the request with a one-cycle acknowledge pulse. A running flag and the live count can be read back.

Top module: `interval_timer`

## Requirements
- R1: After reset, `count` is 0, `running` is 0 and `irq_pending` is 0.
- R2: A `start` pulse loads `count` with `cfg_reload`, sets `running` and clears the prescaler. The new count is visible in the cycle after the pulse.
- R3: While running, `count` steps down by one every 2^p clocks, where p is `cfg_prescale` (0 gives every clock, 7 gives every 128 clocks). Between steps it holds its value.
- R4: Expiry occurs on the prescaled tick that finds `count` at 0, which is exactly (reload+1) × 2^p clock edges after the start edge. Expiry sets `irq_pending` at that edge.
- R5: With `cfg_continuous` = 0 (one-shot), expiry clears `running` and leaves `count` at 0. No further expiry happens until the next `start`.
- R6: With `cfg_continuous` = 1, expiry reloads `count` from `cfg_reload` and leaves `running` set. An interrupt request follows every (reload+1) × 2^p clocks.
- R7: An `irq_ack` pulse clears `irq_pending` at the next edge. If an expiry falls on the same edge as the acknowledge, `irq_pending` stays set.
- R8: A `start` pulse while the timer is running restarts the count from `cfg_reload`. The next expiry is then timed from the new start edge.
- R9: A `stop` pulse clears `running` and freezes `count` at its current value. If `start` and `stop` arrive in the same cycle, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_reload | input | 12 | Value loaded at start and at each continuous-mode reload |
| cfg_prescale | input | 3 | Prescale exponent p; the tick rate is clk / 2^p |
| cfg_continuous | input | 1 | 1 selects continuous mode, 0 selects one-shot |
| start | input | 1 | One-cycle pulse that loads the counter and starts the timer |
| stop | input | 1 | One-cycle pulse that halts the timer |
| irq_ack | input | 1 | One-cycle pulse that clears the pending request |
| irq_pending | output | 1 | Sticky interrupt request |
| running | output | 1 | High while the timer is counting |
| count | output | 12 | Current counter value |

## Verification
A prescaler that is out of phase shows up as an expiry that lands a few cycles early or late. The scoreboard compares each rising edge of `irq_pending` against the exact cycle computed from the reload value and the prescale exponent, so such a fault is reported at the first interrupt. A wrong mode or run state shows up within one period, either as an interrupt that was not expected after a one-shot expiry or as a continuous-mode interrupt that never arrives. A restart that fails to reload is caught when the interrupt arrives at the time of the abandoned count. A wrong acknowledge priority is caught in the same cycle, by sampling `irq_pending` just after an acknowledge that coincides with an expiry.

// File: rtl/interval_timer_pkg.sv
// Package: shared widths and mode encoding for the interval timer.
// Assumes nothing beyond IEEE 1800-2017 package support.
package interval_timer_pkg;
    localparam int CNT_W_DEF = 12;
    localparam int PSC_W_DEF = 3;

    typedef enum logic {
        TMR_ONE_SHOT   = 1'b0,
        TMR_CONTINUOUS = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Produces a one-cycle tick every 2^sel enabled clocks, using a free binary
// counter and a mask of its low sel bits. Assumes sel is held steady during
// a run; clear restarts the phase so the first tick lands 2^sel clocks later.
module tmr_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;

    // Build the mask of the low sel bits that must all be one for a tick.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    // Advance the divider while enabled; restart it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (clear) begin
            div_cnt <= '0;
        end else if (enable) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = enable && ((div_cnt & mask) == mask);
endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Holds the down counter. Start loads the reload value. Each tick steps the
// count down; a tick at zero is an expiry, which reloads in continuous mode
// and holds zero in one-shot mode. Assumes tick only occurs while running.
module tmr_counter
    import interval_timer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = tick && at_zero && !start;

    // Load on start, reload or hold on expiry, otherwise step down per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start) begin
            count <= reload;
        end else if (tick) begin
            if (!at_zero) begin
                count <= count - 1'b1;
            end else if (mode == TMR_CONTINUOUS) begin
                count <= reload;
            end
        end
    end
endmodule

// File: rtl/tmr_run_ctrl.sv
// Module: tmr_run_ctrl
// Keeps the running flag. Start has priority over stop. A one-shot expiry
// ends the run. Assumes start, stop and expire are single-cycle events.
module tmr_run_ctrl
    import interval_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      stop,
    input  logic      expire,
    input  tmr_mode_e mode,
    output logic      running
);
    // Update the run state from software controls and one-shot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
        end else if (stop) begin
            running <= 1'b0;
        end else if (expire && (mode == TMR_ONE_SHOT)) begin
            running <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_irq_flag.sv
// Module: tmr_irq_flag
// Sticky interrupt request. It is set by an expiry and cleared by an
// acknowledge; when both fall on the same edge the expiry wins.
module tmr_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    output logic pending
);
    // Set on expiry, otherwise clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (expire) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer
// Top level of the prescaled countdown interval timer. It joins the
// prescaler, the down counter, the run control and the interrupt flag.
// Assumes the configuration inputs are stable while the timer runs.
// A stop freezes the count in its own cycle, because it masks the tick.
module interval_timer
    import interval_timer_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PSC_W = PSC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic [PSC_W-1:0] cfg_prescale,
    input  logic             cfg_continuous,
    input  logic             start,
    input  logic             stop,
    input  logic             irq_ack,
    output logic             irq_pending,
    output logic             running,
    output logic [CNT_W-1:0] count
);
    logic      tick;
    logic      expire;
    logic      psc_enable;
    tmr_mode_e mode;

    assign mode       = cfg_continuous ? TMR_CONTINUOUS : TMR_ONE_SHOT;
    assign psc_enable = running && !stop;

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .enable (psc_enable),
        .sel    (cfg_prescale),
        .tick   (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tick   (tick),
        .mode   (mode),
        .reload (cfg_reload),
        .count  (count),
        .expire (expire)
    );

    tmr_run_ctrl u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .expire  (expire),
        .mode    (mode),
        .running (running)
    );

    tmr_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .ack     (irq_ack),
        .pending (irq_pending)
    );
endmodule

// File: rtl/interval_timer_checker.sv
// Module: interval_timer_checker
// Property checks for interval_timer, attached to it with a bind.
module interval_timer_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic             irq_ack,
    input logic             cfg_continuous,
    input logic [CNT_W-1:0] cfg_reload,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             irq_pending,
    input logic             tick,
    input logic             expire
);
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && count == $past(cfg_reload)));

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(count));

    assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> running);

    assert_expire_sets_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_pending);

    assert_oneshot_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cfg_continuous) |=> (!running && count == '0));

    assert_cont_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cfg_continuous) |=> (running && count == $past(cfg_reload)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !expire) |=> !irq_pending);

    assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> (!running && $stable(count)));
endmodule

bind interval_timer interval_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .stop           (stop),
    .irq_ack        (irq_ack),
    .cfg_continuous (cfg_continuous),
    .cfg_reload     (cfg_reload),
    .count          (count),
    .running        (running),
    .irq_pending    (irq_pending),
    .tick           (tick),
    .expire         (expire)
);

// File: tb/interval_timer_bench.sv
// Bench for interval_timer: the driver tasks push expected interrupt cycles
// into a queue, and a monitor pops them on each rising edge of irq_pending.
module interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_reload = '0;
    logic [2:0]  cfg_prescale = '0;
    logic        cfg_continuous = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_pending;
    logic        running;
    logic [11:0] count;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit auto_ack = 1'b1;
    int ack_at = -1;
    bit prev_pend = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    interval_timer u_interval_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_reload     (cfg_reload),
        .cfg_prescale   (cfg_prescale),
        .cfg_continuous (cfg_continuous),
        .start          (start),
        .stop           (stop),
        .irq_ack        (irq_ack),
        .irq_pending    (irq_pending),
        .running        (running),
        .count          (count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Start the timer; returns at the negedge just after the start edge (S).
    task automatic do_start(input int rl, input int p, input bit cont,
                            input int n_irq, output int s);
        cfg_reload = 12'(rl);
        cfg_prescale = 3'(p);
        cfg_continuous = cont;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s = cyc;
        check(count == 12'(rl), "R2 count loaded", int'(count), rl);
        check(running == 1'b1, "R2 running set", int'(running), 1);
        for (int k = 1; k <= n_irq; k++) exp_q.push_back(s + k * (rl + 1) * (1 << p));
    endtask

    // Monitor: pop an expected cycle on each new request and drive acknowledges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_pending && !prev_pend) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected interrupt", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R4 interrupt cycle", cyc, e);
                end
            end
            prev_pend = irq_pending;
        end
        irq_ack = (auto_ack && irq_pending) || (cyc == ack_at);
    end

    initial begin
        int s;
        int s2;
        int held;
        repeat (3) @(negedge clk);
        check(count == 12'd0, "R1 count reset", int'(count), 0);
        check(running == 1'b0, "R1 running reset", int'(running), 0);
        check(irq_pending == 1'b0, "R1 pending reset", int'(irq_pending), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // One-shot, no prescale.
        do_start(5, 0, 1'b0, 1, s);
        wait_until(s + 3);
        check(count == 12'd2, "R3 step per clock", int'(count), 2);
        wait_until(s + 6);
        check(running == 1'b0, "R5 one-shot halts", int'(running), 0);
        check(count == 12'd0, "R5 count at zero", int'(count), 0);
        wait_until(s + 30);
        check(count == 12'd0, "R5 stays stopped", int'(count), 0);

        // One-shot with prescale exponent 2.
        do_start(3, 2, 1'b0, 1, s);
        wait_until(s + 3);
        check(count == 12'd3, "R3 held before tick", int'(count), 3);
        wait_until(s + 4);
        check(count == 12'd2, "R3 step after 4 clocks", int'(count), 2);
        wait_until(s + 24);
        check(running == 1'b0, "R5 prescaled one-shot halts", int'(running), 0);

        // Continuous, prescale exponent 1, period 10.
        do_start(4, 1, 1'b1, 3, s);
        wait_until(s + 32);
        check(running == 1'b1, "R6 still running", int'(running), 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(running == 1'b0, "R9 stop clears running", int'(running), 0);
        check(count == 12'd3, "R9 count frozen", int'(count), 3);
        held = int'(count);
        repeat (25) @(negedge clk);
        check(int'(count) == held, "R9 count stays frozen", int'(count), held);
        check(exp_q.size() == 0, "R6 all periods seen", exp_q.size(), 0);

        // Restart while running.
        do_start(10, 0, 1'b0, 0, s);
        wait_until(s + 4);
        check(count == 12'd6, "R8 counting before restart", int'(count), 6);
        do_start(10, 0, 1'b0, 1, s2);
        check(count == 12'd10, "R8 restart reloads", int'(count), 10);
        wait_until(s2 + 14);
        check(running == 1'b0, "R8 expired from new start", int'(running), 0);
        check(exp_q.size() == 0, "R8 restart interrupt seen", exp_q.size(), 0);

        // Start and stop together: start wins.
        cfg_reload = 12'd50;
        cfg_continuous = 1'b0;
        start = 1'b1;
        stop = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stop = 1'b0;
        check(running == 1'b1, "R9 start beats stop", int'(running), 1);
        check(count == 12'd50, "R9 loaded on tie", int'(count), 50);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(running == 1'b0, "R9 stop after tie", int'(running), 0);

        // Acknowledge on the same edge as an expiry.
        auto_ack = 1'b0;
        do_start(3, 0, 1'b1, 1, s);
        ack_at = s + 7;
        wait_until(s + 8);
        check(irq_pending == 1'b1, "R7 expiry beats ack", int'(irq_pending), 1);
        ack_at = s + 9;
        wait_until(s + 10);
        check(irq_pending == 1'b0, "R7 ack clears", int'(irq_pending), 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        repeat (10) @(negedge clk);
        check(irq_pending == 1'b0, "R7 stays clear after stop", int'(irq_pending), 0);
        check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
        auto_ack = 1'b1;
        ack_at = -1;

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule